// File: doc/BRIEF.md
# Descrambler Lock Confidence Monitor

This block sits on the receive side of a serial link, after frame delineation. It decides whether the local descrambler has caught up with the scrambler at the far end. The input is the scrambler sequence recovered from each received word. The block predicts the next word of that sequence locally and compares each new recovered word with the prediction. A run of correct predictions that reaches a programmable confidence threshold declares lock. Lock also clears a loss-of-lock status bit, which the surrounding logic sends back to the far end.

Counting starts only once delineation is reported. The first valid word seeds the predictor, and the next `threshold` words confirm it, so a clean stream locks after `1 + threshold` words. Once locked, the predictor free-runs. Lock is kept until `MISS_LIMIT` consecutive words disagree with the prediction, or until delineation is lost.

Top module: `scr_lock_mon`

## Requirements
- R1: After a synchronous active-low reset, `lock_o` is 0 and `los_o` is 1.
- R2: While `delin_ok_i` is 0, valid words have no effect. A clock edge that samples `delin_ok_i` low forces the unlocked hunting state and clears every count, so the next valid word after delineation returns only seeds the predictor.
- R3: Prediction rule: from a state `s` of width W, a prediction is formed by W single-bit advances. In each advance, `fb = ^(s & POLY)` and `s = {s[W-2:0], fb}`. With the default `POLY = 16'hB400`, the word expected after a word `w` is the result of advancing `w` in this way.
- R4: In the hunting state, the first valid word only seeds the predictor. After that, each valid word equal to the prediction adds one to a run count. Lock is declared at the clock edge of the word that brings the run count to the threshold, so a clean stream locks on word `1 + threshold`.
- R5: `conf_thr_i` is 4 bits wide. A value of 0 acts as 1, so a clean stream then locks on its second word. A value of 15 requires 16 clean words.
- R6: Before lock, a valid word that differs from the prediction sets the run count to zero and reseeds the predictor from that word.
- R7: `los_o` is the inverse of `lock_o`. It is set from reset and cleared on the same edge that declares lock. It is set again whenever lock is dropped.
- R8: While locked, the predictor advances from its own state on every valid word. A correct word clears the miss count. `MISS_LIMIT` (default 4) consecutive wrong words drop lock and restart confirmation, with the predictor reseeded from the last wrong word. Fewer consecutive misses keep lock.
- R9: A cycle with `rx_vld_i` low and `delin_ok_i` high changes neither output nor any count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_seq_i | input | W (16) | Recovered scrambler sequence word |
| rx_vld_i | input | 1 | Word valid strobe |
| delin_ok_i | input | 1 | Frame delineation achieved |
| conf_thr_i | input | 4 | Confidence threshold, 0 acts as 1 |
| lock_o | output | 1 | Descrambler declared synchronized |
| los_o | output | 1 | Descrambler loss-of-lock status bit |

## Verification
A wrong predictor state shows up as a lock that never comes on a clean stream. It also shows up as a lock that falls after exactly `MISS_LIMIT` valid words, because every word then misses. A wrong run count or wrong threshold decoding shifts the lock edge by one or more words from word `1 + threshold`. The bench compares the outputs with its model on every clock, so any of these faults is reported within one clock of the first word where the outputs diverge. A miss count that is cleared wrongly, or not cleared, is exposed by patterns that mix `MISS_LIMIT - 1` misses with single hits.

// File: rtl/scr_lock_pkg.sv
// Shared types for the descrambler lock confidence monitor.
// Assumes: nothing beyond a standard SystemVerilog elaborator.
package scr_lock_pkg;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCK    = 2'd2
    } lock_st_e;

    localparam int unsigned DEF_THRESH = 8;

endpackage

// File: rtl/scr_lock_pred.sv
// Sequence predictor: holds the word expected next in the scrambler sequence.
// load reseeds the predictor from a received word; step advances it from its own state.
// Assumes load and step are never high together, or else load wins.
module scr_lock_pred #(
    parameter int unsigned     W    = 16,
    parameter logic [W-1:0]    POLY = 16'hB400
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] word,
    output logic [W-1:0] pred
);

    // W single-bit LFSR advances of a state
    function automatic logic [W-1:0] adv_word(input logic [W-1:0] s_in);
        logic [W-1:0] s;
        logic         fb;
        s = s_in;
        for (int i = 0; i < int'(W); i++) begin
            fb = ^(s & POLY);
            s  = {s[W-2:0], fb};
        end
        return s;
    endfunction

    // Prediction register: reseed, free-run or hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            pred <= '0;
        else if (load)
            pred <= adv_word(word);
        else if (step)
            pred <= adv_word(pred);
    end

endmodule

// File: rtl/scr_lock_cnt.sv
// Run counter with synchronous clear (priority) and increment.
// Assumes the controller never increments past the top of CW bits.
module scr_lock_cnt #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    // Count register: clear wins over increment
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + ONE;
    end

endmodule

// File: rtl/scr_lock_mon.sv
// Descrambler lock confidence monitor.
// Seeds a sequence predictor from the first valid word after delineation. Counts
// consecutive correct predictions up to a 4-bit threshold (0 acts as 1) and then
// declares lock. While locked, the predictor free-runs, and MISS_LIMIT consecutive
// misses drop lock. Loss of delineation forces the hunting state.
// Assumes: inputs synchronous to clk; MISS_LIMIT >= 1.
module scr_lock_mon
    import scr_lock_pkg::*;
#(
    parameter int unsigned  W          = 16,
    parameter logic [W-1:0] POLY       = 16'hB400,
    parameter int unsigned  THR_W      = 4,
    parameter int unsigned  MISS_LIMIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     rx_seq_i,
    input  logic             rx_vld_i,
    input  logic             delin_ok_i,
    input  logic [THR_W-1:0] conf_thr_i,
    output logic             lock_o,
    output logic             los_o
);

    localparam int unsigned   MW       = $clog2(MISS_LIMIT + 1);
    localparam int unsigned   XW       = THR_W + 1;
    localparam logic [MW-1:0] MISS_TOP = MW'(MISS_LIMIT - 1);

    lock_st_e         st_q, st_d;
    logic [W-1:0]     pred_q;
    logic [THR_W-1:0] run_q;
    logic [MW-1:0]    miss_q;
    logic             p_load, p_step;
    logic             run_clr, run_inc, miss_clr, miss_inc;
    logic             ev, hit;
    logic [THR_W-1:0] thr_eff;
    logic             run_done;

    assign ev       = rx_vld_i && delin_ok_i;
    assign hit      = (rx_seq_i == pred_q);
    assign thr_eff  = (conf_thr_i == '0) ? {{(THR_W-1){1'b0}}, 1'b1} : conf_thr_i;
    assign run_done = (XW'(run_q) + XW'(1)) >= XW'(thr_eff);

    scr_lock_pred #(.W(W), .POLY(POLY)) u_pred (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (p_load),
        .step  (p_step),
        .word  (rx_seq_i),
        .pred  (pred_q)
    );

    scr_lock_cnt #(.CW(THR_W)) u_run (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (run_clr),
        .inc   (run_inc),
        .cnt   (run_q)
    );

    scr_lock_cnt #(.CW(MW)) u_miss (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (miss_clr),
        .inc   (miss_inc),
        .cnt   (miss_q)
    );

    // Next-state and counter/predictor control decisions
    always_comb begin
        st_d     = st_q;
        p_load   = 1'b0;
        p_step   = 1'b0;
        run_clr  = 1'b0;
        run_inc  = 1'b0;
        miss_clr = 1'b0;
        miss_inc = 1'b0;
        if (!delin_ok_i) begin
            st_d     = ST_HUNT;
            run_clr  = 1'b1;
            miss_clr = 1'b1;
        end else begin
            case (st_q)
                ST_HUNT: begin
                    run_clr  = 1'b1;
                    miss_clr = 1'b1;
                    if (ev) begin
                        p_load = 1'b1;
                        st_d   = ST_CONFIRM;
                    end
                end
                ST_CONFIRM: begin
                    miss_clr = 1'b1;
                    if (ev) begin
                        p_load = 1'b1;
                        if (!hit) begin
                            run_clr = 1'b1;
                        end else if (run_done) begin
                            run_clr = 1'b1;
                            st_d    = ST_LOCK;
                        end else begin
                            run_inc = 1'b1;
                        end
                    end
                end
                ST_LOCK: begin
                    run_clr = 1'b1;
                    if (ev) begin
                        if (hit) begin
                            miss_clr = 1'b1;
                            p_step   = 1'b1;
                        end else if (miss_q == MISS_TOP) begin
                            miss_clr = 1'b1;
                            p_load   = 1'b1;
                            st_d     = ST_CONFIRM;
                        end else begin
                            miss_inc = 1'b1;
                            p_step   = 1'b1;
                        end
                    end
                end
                default: st_d = ST_HUNT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_HUNT;
        else
            st_q <= st_d;
    end

    assign lock_o = (st_q == ST_LOCK);
    assign los_o  = (st_q != ST_LOCK);

endmodule

// File: rtl/scr_lock_mon_chk.sv
// Property checker for scr_lock_mon, attached by bind below.
// Assumes the bound instance exposes its predictor output as pred_q.
module scr_lock_mon_chk #(
    parameter int unsigned W     = 16,
    parameter int unsigned THR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [W-1:0]     rx_seq_i,
    input logic             rx_vld_i,
    input logic             delin_ok_i,
    input logic [THR_W-1:0] conf_thr_i,
    input logic             lock_o,
    input logic             los_o,
    input logic [W-1:0]     pred_q
);

    // R2: delineation loss forces unlock on the next edge
    a_r2_delin_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        !delin_ok_i |=> !lock_o);

    // R4: lock only rises on an accepted word
    a_r4_lock_on_word: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(rx_vld_i && delin_ok_i));

    // R4: lock only rises on a correct prediction
    a_r4_lock_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(rx_seq_i == pred_q));

    // R8: a correct word while locked keeps lock
    a_r8_hit_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o && rx_vld_i && delin_ok_i && rx_seq_i == pred_q) |=> lock_o);

    // R9: idle cycles change nothing
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_vld_i && delin_ok_i) |=> ($stable(lock_o) && $stable(los_o)));

endmodule

bind scr_lock_mon scr_lock_mon_chk #(.W(W), .THR_W(THR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_seq_i   (rx_seq_i),
    .rx_vld_i   (rx_vld_i),
    .delin_ok_i (delin_ok_i),
    .conf_thr_i (conf_thr_i),
    .lock_o     (lock_o),
    .los_o      (los_o),
    .pred_q     (pred_q)
);

// File: tb/scr_lock_mon_tb.sv
// Self-checking bench: behavioural model compared every clock, plus directed checks.
module scr_lock_mon_tb;

    localparam logic [15:0] POLY = 16'hB400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] rx_seq_i = '0;
    logic        rx_vld_i = 1'b0;
    logic        delin_ok_i = 1'b0;
    logic [3:0]  conf_thr_i = 4'd8;
    logic        lock_o, los_o;

    int          n_run = 0;
    int          n_fail = 0;
    string       cur_req = "R1";
    bit          done = 1'b0;

    // model state
    int          m_st = 0;      // 0 hunt, 1 confirm, 2 locked
    int          m_run = 0;
    int          m_miss = 0;
    logic [15:0] m_pred = '0;
    logic [15:0] gen = 16'h1D2C;

    always #4 clk = ~clk;

    scr_lock_mon u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_seq_i   (rx_seq_i),
        .rx_vld_i   (rx_vld_i),
        .delin_ok_i (delin_ok_i),
        .conf_thr_i (conf_thr_i),
        .lock_o     (lock_o),
        .los_o      (los_o)
    );

    function automatic logic [15:0] nxt(input logic [15:0] v);
        logic [15:0] s = v;
        for (int k = 0; k < 16; k++) s = {s[14:0], ^(s & POLY)};
        return s;
    endfunction

    // reference model update
    always @(posedge clk) begin
        int thr;
        thr = (conf_thr_i == 0) ? 1 : int'(conf_thr_i);
        if (!rst_n) begin
            m_st = 0; m_run = 0; m_miss = 0; m_pred = '0;
        end else if (!delin_ok_i) begin
            m_st = 0; m_run = 0; m_miss = 0;
        end else if (rx_vld_i) begin
            if (m_st == 0) begin
                m_pred = nxt(rx_seq_i); m_st = 1;
            end else if (m_st == 1) begin
                if (rx_seq_i == m_pred) begin
                    m_run++;
                    if (m_run >= thr) begin m_st = 2; m_run = 0; m_miss = 0; end
                end else m_run = 0;
                m_pred = nxt(rx_seq_i);
            end else begin
                if (rx_seq_i == m_pred) begin
                    m_miss = 0; m_pred = nxt(m_pred);
                end else begin
                    m_miss++;
                    if (m_miss == 4) begin
                        m_st = 1; m_run = 0; m_miss = 0; m_pred = nxt(rx_seq_i);
                    end else m_pred = nxt(m_pred);
                end
            end
        end
    end

    // per-clock comparison of outputs
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_run++;
            if (lock_o !== (m_st == 2) || los_o !== (m_st != 2)) begin
                n_fail++;
                $display("FAIL %s model compare: lock=%b los=%b expected lock=%b los=%b",
                         cur_req, lock_o, los_o, m_st == 2, m_st != 2);
            end
        end
    end

    task automatic chk(input string req, input logic exp_lock);
        n_run++;
        if (lock_o !== exp_lock || los_o !== !exp_lock) begin
            n_fail++;
            $display("FAIL %s directed: lock=%b los=%b expected lock=%b los=%b",
                     req, lock_o, los_o, exp_lock, !exp_lock);
        end
    endtask

    task automatic send(input logic [15:0] w);
        rx_seq_i = w; rx_vld_i = 1'b1;
        @(negedge clk);
        rx_vld_i = 1'b0;
    endtask

    task automatic good(input int n);
        for (int i = 0; i < n; i++) begin send(gen); gen = nxt(gen); end
    endtask

    task automatic bad(input int n);
        for (int i = 0; i < n; i++) begin send(gen ^ 16'h0001); gen = nxt(gen); end
    endtask

    task automatic idle(input int n);
        rx_vld_i = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic unlock();
        delin_ok_i = 1'b0; idle(1); delin_ok_i = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        chk("R1", 1'b0);

        cur_req = "R2";                      // words ignored without delineation
        good(12); chk("R2", 1'b0);
        delin_ok_i = 1'b1;

        cur_req = "R4";                      // default threshold 8: lock on word 9
        good(8); chk("R4", 1'b0);
        good(1); chk("R4", 1'b1);

        cur_req = "R2";                      // delineation loss drops lock
        delin_ok_i = 1'b0; idle(1); chk("R2", 1'b0);
        delin_ok_i = 1'b1;
        good(8); chk("R2", 1'b0);
        good(1); chk("R2", 1'b1);

        cur_req = "R6";                      // mismatch before lock restarts run
        unlock();
        good(6); bad(1); good(8); chk("R6", 1'b0);
        good(1); chk("R6", 1'b1);

        cur_req = "R9";                      // gaps do not disturb
        unlock();
        good(4); idle(5); good(4); chk("R9", 1'b0);
        idle(3); good(1); chk("R9", 1'b1);
        idle(4); chk("R9", 1'b1);

        cur_req = "R5";                      // threshold 0 acts as 1
        conf_thr_i = 4'd0; unlock();
        good(1); chk("R5", 1'b0);
        good(1); chk("R5", 1'b1);
        conf_thr_i = 4'd15; unlock();        // threshold 15
        good(15); chk("R5", 1'b0);
        good(1); chk("R5", 1'b1);

        cur_req = "R8";                      // misses while locked
        conf_thr_i = 4'd3;
        bad(3); chk("R8", 1'b1);
        good(1); bad(3); chk("R8", 1'b1);
        good(1); chk("R8", 1'b1);
        bad(4); chk("R8", 1'b0);
        cur_req = "R7";                      // reseeded from the bad word: relock on good 1+3
        good(3); chk("R7", 1'b0);
        good(1); chk("R7", 1'b1);

        cur_req = "R3";                      // explicit sequence rule
        unlock();
        send(16'h0001); send(nxt(16'h0001)); send(nxt(nxt(16'h0001)));
        chk("R3", 1'b0);
        send(nxt(nxt(nxt(16'h0001)))); chk("R3", 1'b1);

        idle(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule